// File: doc/BRIEF.md
# Speech Level Automatic Gain Control

This block regulates the gain of one audio input channel so that recorded speech stays at a steady loudness. It sees the signed samples that leave the amplifier and its converter, each marked by a one-cycle strobe. It keeps a running mean of their magnitude and compares that mean with a selectable target. From the comparison it produces a gain code that goes back to the amplifier. The gain code uses 0.5 dB per LSB, and code 0 is 0 dB. A loud level lowers the code at a programmable attack pace. A quiet level raises it at a separate, slower decay pace. The code never goes above a programmable ceiling.

A noise gate guards against amplifying silence. When the level stays under a programmable floor for a debounce number of strobes, the gate closes. It then walks the gain down to 0 dB and holds it there. The gate opens again only when the level climbs above the floor scaled up by a hysteresis factor. One instance serves one channel. A stereo recorder uses two instances, each with its own settings.

Top module: `speech_agc`

## Requirements
- R1: The level is a leaky mean of the sample magnitude, acc += |x| - acc/16, level = acc/16. The sample -32768 counts as magnitude 32767, so a steady stream of -32768 drives the level to 32767. A steady stream of ±A settles at level A.
- R2: target_sel picks the target level. The choices are 0:17396 (-5.5 dB), 1:13045, 2:10362, 3:8231, 4:6538, 5:4631, 6:3277 and 7:2067 (-24 dB), all against full scale 32768. The level is compared with the selected target.
- R3: When the level is below target, the gain code rises by 1 every decay_len strobes. A value of 0 counts as 1. The count restarts whenever the direction changes, and the code never rises past the ceiling.
- R4: When the level is above target, the gain code falls by 1 every attack_len strobes, counted the same way as in R3. The code never falls below 0.
- R5: The gain code changes only on a clock edge that has sample_strobe high.
- R6: The ceiling is min(max_gain, 119). A gain code above the ceiling drops to the ceiling at the next strobe. This takes priority over every other rule.
- R7: sat_flag is high while the gate is open, the level is below target and the gain code equals the ceiling.
- R8: With gate_off low, gate_flag rises at the strobe that completes debounce_len consecutive strobes with the level below the noise floor. A value of 0 counts as 1.
- R9: While gate_flag is high, each strobe lowers the gain code by 1 until it reaches 0, and the code then stays at 0.
- R10: An active gate opens at a strobe where the level exceeds floor << hyst_sel. A level between the floor and that bound keeps the gate closed.
- R11: gate_off clears gate_flag at the next clock edge and holds the gate open.
- R12: noise_sel picks the floor in 10 dB steps: 0:-30 dB (1036), 1:-40 dB (327), 2:-50 dB (103), 3:-60 dB (32), 4:-70 dB (10), 5:-80 dB (3), 6 and 7:-90 dB (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_strobe | input | 1 | One-cycle mark of a valid sample |
| sample_in | input | 16 | Signed sample after the amplifier |
| target_sel | input | 3 | Target level choice |
| attack_len | input | 8 | Strobes per 0.5 dB cut |
| decay_len | input | 8 | Strobes per 0.5 dB boost |
| noise_sel | input | 3 | Noise floor choice |
| gate_off | input | 1 | Disables the noise gate |
| hyst_sel | input | 2 | Shift applied to the floor for gate opening |
| debounce_len | input | 4 | Quiet strobes needed to close the gate |
| max_gain | input | 7 | Gain ceiling code |
| gain_code | output | 7 | Gain to the amplifier, 0.5 dB per LSB |
| gate_flag | output | 1 | Noise gate closed |
| sat_flag | output | 1 | Boost wanted but held at the ceiling |

## Verification
Several rules are checked by assertions on every cycle. The level never reaches the sign bit. The gain code holds between strobes. A boost or cut moves the code by exactly one. A strobe leaves the code at or below the ceiling. A closed gate walks the code down by one per strobe. gate_off opens the gate within one clock. The bench scenarios cover what only a history of input can show: the exact boost and cut paces, the effect of the target choice, the debounce count before the gate closes, the hysteresis band that keeps the gate closed, and the handling of the most negative sample.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int GAIN_W   = 7;
  localparam int GAIN_TOP = 119;

  typedef enum logic [1:0] {DIR_HOLD, DIR_UP, DIR_DOWN} agc_dir_e;

  // target levels as Q16 fractions of full scale, -5.5 dB down to -24 dB
  function automatic logic [31:0] target_thr(input logic [2:0] sel, input int w);
    logic [63:0] frac;
    case (sel)
      3'd0: frac = 64'd34793;
      3'd1: frac = 64'd26090;
      3'd2: frac = 64'd20724;
      3'd3: frac = 64'd16462;
      3'd4: frac = 64'd13076;
      3'd5: frac = 64'd9262;
      3'd6: frac = 64'd6554;
      default: frac = 64'd4135;
    endcase
    return 32'((frac << (w - 1)) >> 16);
  endfunction

  // noise floors as Q24 fractions, -30 dB down to -90 dB in 10 dB steps
  function automatic logic [31:0] noise_thr(input logic [2:0] sel, input int w);
    logic [63:0] frac;
    case (sel)
      3'd0: frac = 64'd530542;
      3'd1: frac = 64'd167772;
      3'd2: frac = 64'd53054;
      3'd3: frac = 64'd16777;
      3'd4: frac = 64'd5305;
      3'd5: frac = 64'd1678;
      default: frac = 64'd531;
    endcase
    return 32'((frac << (w - 1)) >> 24);
  endfunction

  function automatic logic [GAIN_W-1:0] ceiling(input logic [GAIN_W-1:0] mx);
    return (mx > GAIN_W'(GAIN_TOP)) ? GAIN_W'(GAIN_TOP) : mx;
  endfunction
endpackage

// File: rtl/agc_level_meter.sv
module agc_level_meter #(
  parameter int SAMPLE_W  = 16,
  parameter int AVG_SHIFT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strobe,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W-1:0]        level
);
  localparam int ACC_W = SAMPLE_W - 1 + AVG_SHIFT;

  function automatic logic [SAMPLE_W-2:0] magnitude(input logic signed [SAMPLE_W-1:0] s);
    logic signed [SAMPLE_W-1:0] neg;
    neg = -s;
    if (!s[SAMPLE_W-1]) return s[SAMPLE_W-2:0];
    if (s == {1'b1, {(SAMPLE_W-1){1'b0}}}) return '1;
    return neg[SAMPLE_W-2:0];
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   acc_sum;

  assign acc_sum = (ACC_W+1)'(acc_q) - (ACC_W+1)'(acc_q >> AVG_SHIFT)
                 + (ACC_W+1)'(magnitude(sample));

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (strobe) acc_q <= acc_sum[ACC_W-1:0];
  end

  assign level = {1'b0, acc_q[ACC_W-1:AVG_SHIFT]};
endmodule

// File: rtl/agc_noise_gate.sv
module agc_noise_gate #(
  parameter int SAMPLE_W = 16,
  parameter int DEB_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic                gate_off,
  input  logic [SAMPLE_W-1:0] level,
  input  logic [SAMPLE_W-1:0] floor_thr,
  input  logic [1:0]          hyst_sel,
  input  logic [DEB_W-1:0]    deb_len,
  output logic                gate_q,
  output logic                gate_enter,
  output logic                gate_exit
);
  localparam int EXT_W = SAMPLE_W + 3;

  logic [DEB_W-1:0] deb_q;
  logic [DEB_W:0]   deb_inc;
  logic [EXT_W-1:0] open_thr;
  logic             quiet;

  assign open_thr   = EXT_W'(floor_thr) << hyst_sel;
  assign quiet      = level < floor_thr;
  assign deb_inc    = (DEB_W+1)'(deb_q) + 1'b1;
  assign gate_enter = strobe && !gate_off && !gate_q && quiet
                      && (deb_inc >= (DEB_W+1)'(deb_len));
  assign gate_exit  = strobe && !gate_off && gate_q && (EXT_W'(level) > open_thr);

  always_ff @(posedge clk) begin
    if (!rst_n || gate_off) begin
      gate_q <= 1'b0;
      deb_q  <= '0;
    end else if (strobe) begin
      if (gate_q) begin
        if (gate_exit) gate_q <= 1'b0;
        deb_q <= '0;
      end else if (gate_enter) begin
        gate_q <= 1'b1;
        deb_q  <= '0;
      end else begin
        deb_q <= quiet ? deb_inc[DEB_W-1:0] : '0;
      end
    end
  end
endmodule

// File: rtl/agc_gain_stepper.sv
module agc_gain_stepper
  import agc_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RATE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic [SAMPLE_W-1:0] level,
  input  logic [SAMPLE_W-1:0] target,
  input  logic                gated,
  input  logic [RATE_W-1:0]   attack_len,
  input  logic [RATE_W-1:0]   decay_len,
  input  logic [GAIN_W-1:0]   max_gain,
  output logic [GAIN_W-1:0]   gain_q,
  output logic                sat,
  output logic                step_up,
  output logic                step_down
);
  agc_dir_e            dir, dir_q, dir_n;
  logic [RATE_W-1:0]   cnt_q, cnt_n, base;
  logic [RATE_W:0]     base_inc;
  logic [RATE_W-1:0]   interval;
  logic [GAIN_W-1:0]   gain_n, ceil_g;

  assign ceil_g   = ceiling(max_gain);
  assign dir      = (level > target) ? DIR_DOWN : (level < target) ? DIR_UP : DIR_HOLD;
  assign interval = (dir == DIR_UP) ? decay_len : attack_len;
  assign base     = (dir != dir_q) ? '0 : cnt_q;
  assign base_inc = (RATE_W+1)'(base) + 1'b1;
  assign sat      = !gated && (dir == DIR_UP) && (gain_q == ceil_g);

  always_comb begin
    gain_n    = gain_q;
    cnt_n     = cnt_q;
    dir_n     = dir_q;
    step_up   = 1'b0;
    step_down = 1'b0;
    if (strobe) begin
      if (gain_q > ceil_g) begin
        gain_n = ceil_g;
        cnt_n  = '0;
        dir_n  = DIR_HOLD;
      end else if (gated) begin
        gain_n = (gain_q == '0) ? '0 : gain_q - 1'b1;
        cnt_n  = '0;
        dir_n  = DIR_HOLD;
      end else begin
        dir_n = dir;
        if (dir == DIR_HOLD) begin
          cnt_n = '0;
        end else if (base_inc >= (RATE_W+1)'(interval)) begin
          cnt_n     = '0;
          step_up   = (dir == DIR_UP) && (gain_q < ceil_g);
          step_down = (dir == DIR_DOWN) && (gain_q != '0);
        end else begin
          cnt_n = base_inc[RATE_W-1:0];
        end
        if (step_up)   gain_n = gain_q + 1'b1;
        if (step_down) gain_n = gain_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q <= '0;
      cnt_q  <= '0;
      dir_q  <= DIR_HOLD;
    end else begin
      gain_q <= gain_n;
      cnt_q  <= cnt_n;
      dir_q  <= dir_n;
    end
  end
endmodule

// File: rtl/speech_agc.sv
module speech_agc
  import agc_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int AVG_SHIFT = 4,
  parameter int RATE_W    = 8,
  parameter int DEB_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_strobe,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  input  logic [2:0]                 target_sel,
  input  logic [RATE_W-1:0]          attack_len,
  input  logic [RATE_W-1:0]          decay_len,
  input  logic [2:0]                 noise_sel,
  input  logic                       gate_off,
  input  logic [1:0]                 hyst_sel,
  input  logic [DEB_W-1:0]           debounce_len,
  input  logic [GAIN_W-1:0]          max_gain,
  output logic [GAIN_W-1:0]          gain_code,
  output logic                       gate_flag,
  output logic                       sat_flag
);
  logic [SAMPLE_W-1:0] level, target, floor_thr;
  logic gate_enter, gate_exit, step_up, step_down;

  assign target    = SAMPLE_W'(target_thr(target_sel, SAMPLE_W));
  assign floor_thr = SAMPLE_W'(noise_thr(noise_sel, SAMPLE_W));

  agc_level_meter #(.SAMPLE_W(SAMPLE_W), .AVG_SHIFT(AVG_SHIFT)) u_meter (
    .clk(clk), .rst_n(rst_n), .strobe(sample_strobe), .sample(sample_in), .level(level)
  );

  agc_noise_gate #(.SAMPLE_W(SAMPLE_W), .DEB_W(DEB_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .strobe(sample_strobe), .gate_off(gate_off),
    .level(level), .floor_thr(floor_thr), .hyst_sel(hyst_sel), .deb_len(debounce_len),
    .gate_q(gate_flag), .gate_enter(gate_enter), .gate_exit(gate_exit)
  );

  agc_gain_stepper #(.SAMPLE_W(SAMPLE_W), .RATE_W(RATE_W)) u_step (
    .clk(clk), .rst_n(rst_n), .strobe(sample_strobe), .level(level), .target(target),
    .gated(gate_flag), .attack_len(attack_len), .decay_len(decay_len),
    .max_gain(max_gain), .gain_q(gain_code), .sat(sat_flag),
    .step_up(step_up), .step_down(step_down)
  );
endmodule

// File: rtl/speech_agc_chk.sv
module speech_agc_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_strobe,
  input logic                gate_off,
  input logic [6:0]          max_gain,
  input logic [6:0]          gain_code,
  input logic                gate_flag,
  input logic                sat_flag,
  input logic [SAMPLE_W-1:0] level,
  input logic                step_up,
  input logic                step_down
);
  logic [6:0] top_c;
  assign top_c = (max_gain > 7'd119) ? 7'd119 : max_gain;

  AST_LEVEL_NO_SIGN: assert property (@(posedge clk) disable iff (!rst_n) !level[SAMPLE_W-1]); // R1
  AST_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> gain_code == $past(gain_code) + 7'd1); // R3
  AST_DOWN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    step_down |=> gain_code == $past(gain_code) - 7'd1); // R4
  AST_HOLD_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_strobe |=> $stable(gain_code)); // R5
  AST_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> gain_code <= $past(top_c)); // R6
  AST_SAT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |-> !gate_flag); // R7
  AST_GATE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && gate_flag && gain_code != 7'd0 && gain_code <= top_c)
    |=> gain_code == $past(gain_code) - 7'd1); // R9
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off |=> !gate_flag); // R11
endmodule

bind speech_agc speech_agc_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe), .gate_off(gate_off),
  .max_gain(max_gain), .gain_code(gain_code), .gate_flag(gate_flag), .sat_flag(sat_flag),
  .level(level), .step_up(step_up), .step_down(step_down)
);

// File: tb/tb_speech_agc.sv
module tb_speech_agc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_strobe = 1'b0;
  logic signed [15:0] sample_in = '0;
  logic [2:0] target_sel = 3'd0;
  logic [7:0] attack_len = 8'd1;
  logic [7:0] decay_len = 8'd3;
  logic [2:0] noise_sel = 3'd0;
  logic gate_off = 1'b1;
  logic [1:0] hyst_sel = 2'd1;
  logic [3:0] debounce_len = 4'd4;
  logic [6:0] max_gain = 7'd20;
  logic [6:0] gain_code;
  logic gate_flag, sat_flag;
  int checks = 0;
  int errors = 0;
  bit flip = 1'b0;

  always #2 clk = ~clk;

  speech_agc dut (
    .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe), .sample_in(sample_in),
    .target_sel(target_sel), .attack_len(attack_len), .decay_len(decay_len),
    .noise_sel(noise_sel), .gate_off(gate_off), .hyst_sel(hyst_sel),
    .debounce_len(debounce_len), .max_gain(max_gain),
    .gain_code(gain_code), .gate_flag(gate_flag), .sat_flag(sat_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // n strobes, one every 4 clocks; alternate sign unless fixed
  task automatic feed(input int n, input int amp, input bit fixed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      flip = ~flip;
      sample_in = (fixed || flip) ? 16'(amp) : 16'(-amp);
      sample_strobe = 1'b1;
      @(negedge clk);
      sample_strobe = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(gain_code == 0, "R5 reset gain", gain_code, 0);
    check(!gate_flag && !sat_flag, "R7 reset flags", {gate_flag, sat_flag}, 0);
  endtask

  task automatic t_decay();
    feed(9, 1000, 1'b0);
    check(gain_code == 3, "R3 decay pace", gain_code, 3);
    @(negedge clk); @(negedge clk);
    check(gain_code == 3, "R5 hold without strobe", gain_code, 3);
    feed(60, 1000, 1'b0);
    check(gain_code == 20, "R3 stop at ceiling", gain_code, 20);
    check(sat_flag, "R7 saturation", sat_flag, 1);
  endtask

  task automatic t_clamp();
    max_gain = 7'd10;
    feed(1, 1000, 1'b0);
    check(gain_code == 10, "R6 clamp to new ceiling", gain_code, 10);
    max_gain = 7'd127;
    decay_len = 8'd1;
    feed(130, 1000, 1'b0);
    check(gain_code == 119, "R6 ceiling limited to 119", gain_code, 119);
    max_gain = 7'd20;
    feed(1, 1000, 1'b0);
    check(gain_code == 20, "R6 clamp down", gain_code, 20);
  endtask

  task automatic t_attack();
    attack_len = 8'd255;
    feed(80, 20000, 1'b0);
    check(gain_code == 20, "R4 slow attack holds", gain_code, 20);
    check(!sat_flag, "R7 no saturation when loud", sat_flag, 0);
    attack_len = 8'd2;
    feed(1, 20000, 1'b0);
    check(gain_code == 19, "R4 due step", gain_code, 19);
    feed(10, 20000, 1'b0);
    check(gain_code == 14, "R4 attack pace", gain_code, 14);
    feed(30, 20000, 1'b0);
    check(gain_code == 0, "R4 floor at zero", gain_code, 0);
  endtask

  task automatic t_target();
    max_gain = 7'd10;
    decay_len = 8'd1;
    target_sel = 3'd7;
    feed(60, 3000, 1'b0);
    check(gain_code == 0, "R2 3000 above -24 dB target", gain_code, 0);
    feed(80, 1500, 1'b0);
    check(gain_code == 10, "R2 1500 below -24 dB target", gain_code, 10);
    target_sel = 3'd0;
  endtask

  task automatic t_gate();
    feed(100, 500, 1'b0);
    noise_sel = 3'd0;
    hyst_sel = 2'd1;
    debounce_len = 4'd4;
    gate_off = 1'b0;
    feed(3, 500, 1'b0);
    check(!gate_flag, "R8 debounce not yet", gate_flag, 0);
    feed(1, 500, 1'b0);
    check(gate_flag, "R8 gate after 4 quiet", gate_flag, 1);
    check(gain_code == 10, "R9 gain before walk", gain_code, 10);
    feed(1, 500, 1'b0);
    check(gain_code == 9, "R9 walk one step", gain_code, 9);
    feed(20, 500, 1'b0);
    check(gain_code == 0 && gate_flag, "R9 held at 0 dB", gain_code, 0);
    check(!sat_flag, "R7 no saturation while gated", sat_flag, 0);
    feed(100, 1500, 1'b0);
    check(gate_flag, "R10 hysteresis keeps gate", gate_flag, 1);
    check(gain_code == 0, "R10 gain held", gain_code, 0);
    feed(100, 3000, 1'b0);
    check(!gate_flag, "R10 gate opens above band", gate_flag, 0);
    check(gain_code == 10, "R10 boost resumes", gain_code, 10);
    noise_sel = 3'd1;
    feed(100, 500, 1'b0);
    check(!gate_flag, "R12 -40 dB floor 327 below 500", gate_flag, 0);
    noise_sel = 3'd0;
    feed(10, 500, 1'b0);
    check(gate_flag, "R12 -30 dB floor 1036 above 500", gate_flag, 1);
    @(negedge clk);
    gate_off = 1'b1;
    @(negedge clk);
    check(!gate_flag, "R11 disable clears flag", gate_flag, 0);
    feed(30, 500, 1'b0);
    check(gain_code == 10 && !gate_flag, "R11 no gating when off", gain_code, 10);
  endtask

  task automatic t_most_negative();
    attack_len = 8'd1;
    feed(60, -32768, 1'b1);
    check(gain_code == 0, "R1 -32768 seen as loud", gain_code, 0);
  endtask

  initial begin
    t_reset();
    t_decay();
    t_clamp();
    t_attack();
    t_target();
    t_gate();
    t_most_negative();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule